// File: doc/BRIEF.md
# Multi-Master Bus Arbiter

This block decides which of several on-chip masters may drive a shared peripheral bus. Each master raises a request line. The arbiter answers with a one-hot grant. The grant only moves between transfers: it holds while the bus-busy input is high, and it holds while the current owner keeps its lock line raised.

Two selection policies are available, and the policy can be switched while the system runs. The first is least-recently-granted. The second walks a small priority table that software loads through a slot/master write port. When nobody requests, the last owner may stay parked on the bus, or the grant may be released.

A parameter chooses how the grant is produced. It can be registered, which gives a shorter path, or combinational, which answers in the same cycle as the request. The block also merges the masters' outgoing data onto the shared bus with a bitwise OR, after masking out every master that is not granted.

Top module: `bus_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set. After reset it is all zeros. A new grant is only ever given to a master whose request bit is set.
- R2: With `mode_fixed_i`=0, the winner is the requesting master that was granted least recently. After reset the history ranks master 0 as least recent, then 1, 2 and so on.
- R3: Every arbitration that picks a winner moves that master to the most-recent end of the history. This happens in both policies.
- R4: With `mode_fixed_i`=1, the table is scanned from slot 0, which has the highest priority, upward. The first slot whose stored master is requesting wins. After reset, slot k holds master k.
- R5: When `cfg_we_i`=1, slot `cfg_slot_i` takes the value `cfg_master_i` at the clock edge. The table may be written at any time. A write does not affect the arbitration made in the same cycle, and it governs arbitrations from the next cycle on.
- R6: While the current owner holds its `lock_i` bit high, it keeps the grant, even if other masters request.
- R7: When no master requests and the owner is not locked, the owner keeps the grant if `park_en_i`=1. Otherwise the grant drops to zero.
- R8: While `busy_i`=1 the grant does not change.
- R9: With REG_GRANT=1 the grant appears one clock edge after the cycle in which it was decided. With REG_GRANT=0 it appears in the same cycle.
- R10: `bus_dout_o` is the bitwise OR of each master's `mst_dout_i` word (master k at bits k*DATA_W upward), ANDed with its grant bit. It is zero when nothing is granted.
- R11: `mode_fixed_i` may change between any two cycles. The next arbitration uses the new policy with the history as it stands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | N_MASTERS | Per-master request |
| lock_i | input | N_MASTERS | Per-master lock, honoured for the current owner |
| busy_i | input | 1 | Transfer in progress; freezes the grant |
| mode_fixed_i | input | 1 | 0 = least-recently-granted, 1 = table order |
| park_en_i | input | 1 | Keep last owner granted when idle |
| cfg_we_i | input | 1 | Priority table write strobe |
| cfg_slot_i | input | IDX_W | Table slot to write (0 = highest) |
| cfg_master_i | input | IDX_W | Master index stored in the slot |
| mst_dout_i | input | N_MASTERS*DATA_W | Concatenated master output words |
| gnt_o | output | N_MASTERS | One-hot grant |
| bus_dout_o | output | DATA_W | OR-combined bus data |

## Verification
In the registered variant, a grant decided from the inputs applied in one cycle shows on `gnt_o` and `bus_dout_o` after the next rising edge. The combinational variant shows the same decision about one nanosecond after the inputs settle, before that edge. The driver applies stimulus on the falling edge and checks the combinational instance at once. It then waits for the rising edge and queues the expected grant and bus word. The monitor pops that entry on the next falling edge, exactly one register stage later. A table write is modelled as taking effect after the arbitration made in its own cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    POL_LRU   = 1'b0,
    POL_TABLE = 1'b1
  } arb_pol_e;
endpackage

// File: rtl/arb_lru_hist.sv
module arb_lru_hist #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  logic [IW-1:0]        upd_idx_i,
  output logic [N-1:0][IW-1:0] order_o
);
  logic [N-1:0][IW-1:0] order_q, order_d;
  logic [IW-1:0]        pos;

  always_comb begin
    pos = '0;
    for (int k = 0; k < N; k++)
      if (order_q[k] == upd_idx_i) pos = IW'(k);
  end

  always_comb begin
    order_d = order_q;
    if (upd_i) begin
      for (int k = 0; k < N-1; k++)
        order_d[k] = (IW'(k) < pos) ? order_q[k] : order_q[k+1];
      order_d[N-1] = upd_idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) order_q[k] <= IW'(k);
    end else if (upd_i) begin
      order_q <= order_d;
    end
  end

  assign order_o = order_q;

  // R3
  mru_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> order_q[N-1] == $past(upd_idx_i));
endmodule

// File: rtl/arb_prio_tbl.sv
module arb_prio_tbl #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [IW-1:0]        slot_i,
  input  logic [IW-1:0]        master_i,
  output logic [N-1:0][IW-1:0] tbl_o
);
  logic [N-1:0][IW-1:0] tbl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) tbl_q[k] <= IW'(k);
    end else if (we_i) begin
      tbl_q[slot_i] <= master_i;
    end
  end

  assign tbl_o = tbl_q;

  // R5
  tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> tbl_q[$past(slot_i)] == $past(master_i));
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][IW-1:0] list_i,
  output logic                 vld_o,
  output logic [IW-1:0]        idx_o
);
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int k = N-1; k >= 0; k--) begin
      if (req_i[list_i[k]]) begin
        vld_o = 1'b1;
        idx_o = list_i[k];
      end
    end
  end
endmodule

// File: rtl/arb_or_mux.sv
module arb_or_mux #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic [N*W-1:0] dout_i,
  input  logic [N-1:0]   gnt_i,
  output logic [W-1:0]   bus_o
);
  logic [N-1:0][W-1:0] masked;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign masked[g] = dout_i[g*W +: W] & {W{gnt_i[g]}};
  end

  always_comb begin
    bus_o = '0;
    for (int k = 0; k < N; k++) bus_o = bus_o | masked[k];
  end
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int DATA_W    = 32,
  parameter bit REG_GRANT = 1'b1,
  parameter int IDX_W     = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_MASTERS-1:0]        req_i,
  input  logic [N_MASTERS-1:0]        lock_i,
  input  logic                        busy_i,
  input  logic                        mode_fixed_i,
  input  logic                        park_en_i,
  input  logic                        cfg_we_i,
  input  logic [IDX_W-1:0]            cfg_slot_i,
  input  logic [IDX_W-1:0]            cfg_master_i,
  input  logic [N_MASTERS*DATA_W-1:0] mst_dout_i,
  output logic [N_MASTERS-1:0]        gnt_o,
  output logic [DATA_W-1:0]           bus_dout_o
);
  localparam int N  = N_MASTERS;
  localparam int IW = IDX_W;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  arb_pol_e             pol;
  logic [N-1:0][IW-1:0] order, tbl, list_sel;
  logic                 pick_vld;
  logic [IW-1:0]        pick_idx;
  logic [IW-1:0]        own_q, own_d;
  logic                 own_vld_q, own_vld_d;
  logic                 own_en, lock_hold, arb_go;
  logic [N-1:0]         gnt;

  assign pol      = arb_pol_e'(mode_fixed_i);
  assign list_sel = (pol == POL_TABLE) ? tbl : order;

  arb_lru_hist #(.N(N), .IW(IW)) i_hist (
    .clk(clk), .rst_n(rst_ni), .upd_i(arb_go), .upd_idx_i(pick_idx),
    .order_o(order));

  arb_prio_tbl #(.N(N), .IW(IW)) i_tbl (
    .clk(clk), .rst_n(rst_ni), .we_i(cfg_we_i), .slot_i(cfg_slot_i),
    .master_i(cfg_master_i), .tbl_o(tbl));

  arb_pick #(.N(N), .IW(IW)) i_pick (
    .req_i(req_i), .list_i(list_sel), .vld_o(pick_vld), .idx_o(pick_idx));

  assign lock_hold = own_vld_q && lock_i[own_q];
  assign own_en    = !busy_i;
  assign arb_go    = own_en && !lock_hold && pick_vld;

  always_comb begin
    own_d     = own_q;
    own_vld_d = own_vld_q;
    if (own_en && !lock_hold) begin
      if (pick_vld) begin
        own_d     = pick_idx;
        own_vld_d = 1'b1;
      end else if (!park_en_i) begin
        own_vld_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q     <= '0;
      own_vld_q <= 1'b0;
    end else if (own_en) begin
      own_q     <= own_d;
      own_vld_q <= own_vld_d;
    end
  end

  if (REG_GRANT) begin : g_reg
    for (genvar g = 0; g < N; g++) begin : g_bit
      assign gnt[g] = own_vld_q && (own_q == IW'(g));
    end
  end else begin : g_comb
    for (genvar g = 0; g < N; g++) begin : g_bit
      assign gnt[g] = own_vld_d && (own_d == IW'(g));
    end
  end

  assign gnt_o = gnt;

  arb_or_mux #(.N(N), .W(DATA_W)) i_or (
    .dout_i(mst_dout_i), .gnt_i(gnt), .bus_o(bus_dout_o));

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R1
  pick_req_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    pick_vld |-> req_i[pick_idx]);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_i |=> ($stable(own_q) && $stable(own_vld_q)));
  // R6
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (lock_hold && !busy_i) |=> (own_vld_q && own_q == $past(own_q)));
  // R7
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_i && !lock_hold && req_i == '0 && !park_en_i) |=> !own_vld_q);
endmodule

// File: tb/test_bus_arbiter.sv
`timescale 1ns/1ps
module test_bus_arbiter;
  localparam int N  = 4;
  localparam int W  = 32;
  localparam int IW = 2;

  typedef struct {
    logic [N-1:0] gnt;
    logic [W-1:0] bus;
    string        tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   req, lock;
  logic           busy, mode_fixed, park_en, cfg_we;
  logic [IW-1:0]  cfg_slot, cfg_master;
  logic [N*W-1:0] dout;
  logic [N-1:0]   gnt_r, gnt_c;
  logic [W-1:0]   bus_r, bus_c;

  int   vectors = 0;
  int   errors  = 0;
  bit   done    = 0;
  exp_t scb[$];

  int   m_own;
  bit   m_vld;
  int   m_order[N];
  int   m_tbl[N];

  always #2.5 clk = ~clk;

  bus_arbiter #(.N_MASTERS(N), .DATA_W(W), .REG_GRANT(1'b1)) i_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .busy_i(busy),
    .mode_fixed_i(mode_fixed), .park_en_i(park_en), .cfg_we_i(cfg_we),
    .cfg_slot_i(cfg_slot), .cfg_master_i(cfg_master), .mst_dout_i(dout),
    .gnt_o(gnt_r), .bus_dout_o(bus_r));

  bus_arbiter #(.N_MASTERS(N), .DATA_W(W), .REG_GRANT(1'b0)) i_bus_arbiter_comb (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .busy_i(busy),
    .mode_fixed_i(mode_fixed), .park_en_i(park_en), .cfg_we_i(cfg_we),
    .cfg_slot_i(cfg_slot), .cfg_master_i(cfg_master), .mst_dout_i(dout),
    .gnt_o(gnt_c), .bus_dout_o(bus_c));

  function automatic logic [W-1:0] word_of(int k);
    return (32'h0001_0000 << k) | 32'(k + 1);
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] m_gnt();
    return m_vld ? (N'(1) << m_own) : '0;
  endfunction

  // Reference model of one arbitration cycle, written from the requirements.
  task automatic step(input logic [N-1:0] r, input logic [N-1:0] lk,
                      input logic b, input logic fx, input logic pk,
                      input logic we, input int slot, input int mst,
                      input string tag);
    int win;
    int list[N];
    int pos;
    logic [N-1:0] eg;
    logic [W-1:0] eb;
    exp_t e;
    req = r; lock = lk; busy = b; mode_fixed = fx; park_en = pk;
    cfg_we = we; cfg_slot = IW'(slot); cfg_master = IW'(mst);
    win = -1;
    for (int k = 0; k < N; k++) list[k] = fx ? m_tbl[k] : m_order[k];
    for (int k = 0; k < N; k++)
      if (win < 0 && r[list[k]]) win = list[k];
    if (!b && !(m_vld && lk[m_own])) begin
      if (win >= 0) begin
        m_own = win; m_vld = 1;
        pos = 0;
        for (int k = 0; k < N; k++) if (m_order[k] == win) pos = k;
        for (int k = pos; k < N-1; k++) m_order[k] = m_order[k+1];
        m_order[N-1] = win;
      end else if (!pk) begin
        m_vld = 0;
      end
    end
    if (we) m_tbl[slot] = mst;
    eg = m_gnt();
    eb = '0;
    for (int k = 0; k < N; k++) if (eg[k]) eb = eb | word_of(k);
    #1;
    check({"R9 comb ", tag}, W'(gnt_c), W'(eg));
    @(posedge clk);
    e.gnt = eg; e.bus = eb; e.tag = tag;
    scb.push_back(e);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (scb.size() > 0) begin
      exp_t e;
      e = scb.pop_front();
      check(e.tag, W'(gnt_r), W'(e.gnt));
      check({"R10 bus ", e.tag}, bus_r, e.bus);
    end
  end

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) dout[k*W +: W] = word_of(k);
    for (int k = 0; k < N; k++) begin m_order[k] = k; m_tbl[k] = k; end
    m_own = 0; m_vld = 0;
    rst_n = 1'b0; req = '0; lock = '0; busy = 0; mode_fixed = 0;
    park_en = 0; cfg_we = 0; cfg_slot = '0; cfg_master = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset gnt", W'(gnt_r), '0);
    check("R10 reset bus", bus_r, '0);

    // R2 R3: all request, rotation by least recently granted
    step(4'b1111, 4'b0, 0, 0, 0, 0, 0, 0, "R2 all req first");
    step(4'b1111, 4'b0, 0, 0, 0, 0, 0, 0, "R3 rotate 1");
    step(4'b1111, 4'b0, 0, 0, 0, 0, 0, 0, "R3 rotate 2");
    step(4'b1111, 4'b0, 0, 0, 0, 0, 0, 0, "R3 rotate 3");
    step(4'b1111, 4'b0, 0, 0, 0, 0, 0, 0, "R3 rotate wrap");
    step(4'b0110, 4'b0, 0, 0, 0, 0, 0, 0, "R2 subset");
    step(4'b1010, 4'b0, 0, 0, 0, 0, 0, 0, "R2 other subset");
    // R8: busy freezes grant though requests change
    step(4'b0101, 4'b0, 1, 0, 0, 0, 0, 0, "R8 busy hold a");
    step(4'b0001, 4'b0, 1, 0, 0, 0, 0, 0, "R8 busy hold b");
    step(4'b0001, 4'b0, 0, 0, 0, 0, 0, 0, "R8 busy released");
    // R6: lock keeps owner
    step(4'b0001, 4'b0001, 0, 0, 0, 0, 0, 0, "R6 lock on");
    step(4'b1110, 4'b0001, 0, 0, 0, 0, 0, 0, "R6 lock others req");
    step(4'b0000, 4'b0001, 0, 0, 0, 0, 0, 0, "R6 lock no req");
    step(4'b1110, 4'b0000, 0, 0, 0, 0, 0, 0, "R6 lock dropped");
    // R7: parking
    step(4'b0000, 4'b0, 0, 0, 1, 0, 0, 0, "R7 parked");
    step(4'b0000, 4'b0, 0, 0, 1, 0, 0, 0, "R7 still parked");
    step(4'b0000, 4'b0, 0, 0, 0, 0, 0, 0, "R7 park off drop");
    step(4'b0000, 4'b0, 0, 0, 0, 0, 0, 0, "R1 idle none");
    // R4: fixed table, reset order
    step(4'b1111, 4'b0, 0, 1, 0, 0, 0, 0, "R4 fixed slot0");
    step(4'b1110, 4'b0, 0, 1, 0, 0, 0, 0, "R4 fixed next");
    // R5: write same cycle does not affect, then takes effect
    step(4'b1111, 4'b0, 0, 1, 0, 1, 0, 3, "R5 write slot0 same cycle");
    step(4'b1111, 4'b0, 0, 1, 0, 1, 3, 0, "R5 write slot3");
    step(4'b1111, 4'b0, 0, 1, 0, 0, 0, 0, "R5 new slot0 wins");
    step(4'b0011, 4'b0, 0, 1, 0, 0, 0, 0, "R4 table scan");
    step(4'b0011, 4'b0, 1, 1, 0, 1, 1, 2, "R5 write while busy");
    step(4'b0110, 4'b0, 0, 1, 0, 0, 0, 0, "R5 slot1 now master2");
    // R11: back to least recently granted with history from fixed mode
    step(4'b1111, 4'b0, 0, 0, 0, 0, 0, 0, "R11 switch to lru");
    step(4'b1111, 4'b0, 0, 0, 0, 0, 0, 0, "R11 lru continue");
    step(4'b1000, 4'b0, 0, 1, 0, 0, 0, 0, "R11 switch to fixed");
    step(4'b0000, 4'b0, 0, 0, 0, 0, 0, 0, "R7 final drop");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule